// File: doc/BRIEF.md
# Branch Direction and Target Predictor with Displacement-Sign Fallback

This block gives the fetch stage a direction and a target for each branch it fetches. The branch's linear address indexes a direct-mapped target buffer. Each buffer entry holds a valid bit, a partial tag, the last resolved target and a 2-bit saturating direction counter. When the indexed entry matches the branch, the counter and the stored target supply the prediction. When it does not match, the direction comes from the sign of the branch displacement: a backward branch is predicted taken and a forward branch is predicted not taken. In that case no target is offered.

The buffer changes only through the retire-side port. A retiring branch that misses takes over its indexed entry. Its counter starts weakly in the direction the branch resolved. A retiring branch that hits moves the counter one step toward the outcome and refreshes the stored target. Fetch lookups never change the buffer.

Calls and returns use a small circular return-address stack. A fetched call pushes its fall-through address, which is the branch address plus the instruction length. A fetched return pops the stack and is predicted taken to the popped address. When the stack is full, a push overwrites the oldest entry. A return that finds the stack empty still predicts taken, but it marks the target invalid.

Top module: `bpred_static_fb`

## Requirements
- R1: After reset every buffer entry is invalid, so any lookup reports `pred_from_btb`=0, and the return stack is empty.
- R2: A non-return lookup that misses the buffer with `fe_disp_neg`=1 (backward) predicts taken, with `pred_from_btb`=0 and `pred_tgt_valid`=0.
- R3: A non-return lookup that misses the buffer with `fe_disp_neg`=0 (forward) predicts not taken, with `pred_from_btb`=0 and `pred_tgt_valid`=0.
- R4: A retire that misses allocates the indexed entry. The next lookup of that address hits, with `pred_tgt_valid`=1, the retired target and the retired direction.
- R5: Fetch lookups never write the buffer. An address that was never retired keeps missing however often it is fetched.
- R6: On a hit the direction is the upper bit of the 2-bit counter (0,1 not taken; 2,3 taken). A new entry starts at 2 if taken and at 1 if not taken, and each retire that hits moves it one step toward the outcome, saturating at 0 and 3.
- R7: The buffer is direct-mapped. Index = address bits [ALIGN_BITS +: log2(BTB_ENTRIES)] and tag = the next TAG_W bits. A retire of a different tag at the same index evicts the older branch.
- R8: A retire that hits replaces the stored target with the resolved target.
- R9: A fetched call (`fe_is_call`=1, `fe_is_ret`=0) pushes `fe_pc`+INST_BYTES. A fetched return pops, and is predicted taken with `pred_from_btb`=0, `pred_tgt_valid`=1 and the most recently pushed address (last in, first out).
- R10: More than RAS_DEPTH pushes overwrite the oldest entries. Later returns give back the newest RAS_DEPTH addresses in reverse order.
- R11: A return fetched with an empty stack predicts taken with `pred_tgt_valid`=0 and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_valid | input | 1 | A branch is being looked up this cycle |
| fe_pc | input | ADDR_W | Linear address of the fetched branch |
| fe_disp_neg | input | 1 | Branch displacement is negative (backward) |
| fe_is_call | input | 1 | Fetched branch is a call |
| fe_is_ret | input | 1 | Fetched branch is a return |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | ADDR_W | Predicted target, meaningful when pred_tgt_valid is 1 |
| pred_tgt_valid | output | 1 | A target is offered |
| pred_from_btb | output | 1 | Prediction came from a matching buffer entry |
| rt_valid | input | 1 | A branch retires this cycle |
| rt_pc | input | ADDR_W | Linear address of the retiring branch |
| rt_taken | input | 1 | Resolved direction |
| rt_target | input | ADDR_W | Resolved target address |

## Verification
The bench walks a single entry through every counter state, including repeated updates that push against both saturation limits. A counter that wraps instead of saturating would flip the prediction at 0 or 3. A new entry that started strong instead of weak would take an extra retire to change direction. Two addresses that share an index are retired one after the other. A design that ignored the tag, or that failed to evict, would report the wrong target or hit for the evicted branch. The return stack is overfilled by two entries and then drained past empty. A pointer or count error would return the wrong addresses in the wrong order, or would offer a stale target on the final empty pop.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'd0,
      CTR_WEAK_NT   = 2'd1,
      CTR_WEAK_T    = 2'd2,
      CTR_STRONG_T  = 2'd3
   } dir_ctr_e;

   function automatic dir_ctr_e ctr_train(input dir_ctr_e cur, input logic taken);
      dir_ctr_e nxt;
      nxt = cur;
      if (taken && cur != CTR_STRONG_T) nxt = dir_ctr_e'(cur + 2'd1);
      else if (!taken && cur != CTR_STRONG_NT) nxt = dir_ctr_e'(cur - 2'd1);
      return nxt;
   endfunction

   function automatic dir_ctr_e ctr_seed(input logic taken);
      return taken ? CTR_WEAK_T : CTR_WEAK_NT;
   endfunction

endpackage

// File: rtl/bp_btb.sv
module bp_btb
   import bp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ENTRIES    = 1024,
   parameter int TAG_W      = 12,
   parameter int ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_hit,
   output logic              lk_taken,
   output logic [ADDR_W-1:0] lk_target,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target
);
   localparam int IDX_W  = $clog2(ENTRIES);
   localparam int TAG_SW = (TAG_W > 0) ? TAG_W : 1;

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_SW-1:0]  tag_q [ENTRIES];
   logic [ADDR_W-1:0]  tgt_q [ENTRIES];
   dir_ctr_e           ctr_q [ENTRIES];

   logic [IDX_W-1:0]  lk_idx, up_idx;
   logic [TAG_SW-1:0] lk_tag, up_tag;
   logic              lk_match, up_match;

   assign lk_idx = lk_pc[ALIGN_BITS +: IDX_W];
   assign up_idx = up_pc[ALIGN_BITS +: IDX_W];

   generate
      if (TAG_W > 0) begin : g_tagged
         assign lk_tag   = lk_pc[ALIGN_BITS + IDX_W +: TAG_SW];
         assign up_tag   = up_pc[ALIGN_BITS + IDX_W +: TAG_SW];
         assign lk_match = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
         assign up_match = vld_q[up_idx] && (tag_q[up_idx] == up_tag);
      end else begin : g_tagless
         assign lk_tag   = '0;
         assign up_tag   = '0;
         assign lk_match = vld_q[lk_idx];
         assign up_match = vld_q[up_idx];
      end
   endgenerate

   assign lk_hit    = lk_match;
   assign lk_taken  = ctr_q[lk_idx][1];
   assign lk_target = tgt_q[lk_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else if (up_valid) vld_q[up_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (up_valid) begin
         tag_q[up_idx] <= up_tag;
         tgt_q[up_idx] <= up_target;
         ctr_q[up_idx] <= up_match ? ctr_train(ctr_q[up_idx], up_taken)
                                   : ctr_seed(up_taken);
      end
   end

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   output logic              top_valid,
   output logic [ADDR_W-1:0] top_addr
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [ADDR_W-1:0] stk_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, ptr_inc, ptr_dec;
   logic [CNT_W-1:0]  cnt_q;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign ptr_inc = wr_ptr_q + 1'b1;
         assign ptr_dec = wr_ptr_q - 1'b1;
      end else begin : g_wrap
         assign ptr_inc = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
         assign ptr_dec = (wr_ptr_q == '0) ? PTR_LAST : wr_ptr_q - 1'b1;
      end
   endgenerate

   assign top_valid = (cnt_q != '0);
   assign top_addr  = stk_q[ptr_dec];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (push) begin
         wr_ptr_q <= ptr_inc;
         if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end else if (pop && top_valid) begin
         wr_ptr_q <= ptr_dec;
         cnt_q    <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) stk_q[wr_ptr_q] <= push_addr;
   end

endmodule

// File: rtl/bp_pick.sv
module bp_pick #(
   parameter int ADDR_W = 32
) (
   input  logic              is_ret,
   input  logic              disp_neg,
   input  logic              btb_hit,
   input  logic              btb_taken,
   input  logic [ADDR_W-1:0] btb_target,
   input  logic              ras_valid,
   input  logic [ADDR_W-1:0] ras_addr,
   output logic              taken,
   output logic [ADDR_W-1:0] target,
   output logic              tgt_valid,
   output logic              from_btb
);
   always_comb begin
      taken     = disp_neg;
      target    = '0;
      tgt_valid = 1'b0;
      from_btb  = 1'b0;
      if (is_ret) begin
         taken     = 1'b1;
         tgt_valid = ras_valid;
         target    = ras_valid ? ras_addr : '0;
      end else if (btb_hit) begin
         taken     = btb_taken;
         target    = btb_target;
         tgt_valid = 1'b1;
         from_btb  = 1'b1;
      end
   end
endmodule

// File: rtl/bpred_static_fb.sv
module bpred_static_fb #(
   parameter int ADDR_W      = 32,
   parameter int BTB_ENTRIES = 1024,
   parameter int TAG_W       = 12,
   parameter int ALIGN_BITS  = 2,
   parameter int INST_BYTES  = 4,
   parameter int RAS_DEPTH   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fe_valid,
   input  logic [ADDR_W-1:0] fe_pc,
   input  logic              fe_disp_neg,
   input  logic              fe_is_call,
   input  logic              fe_is_ret,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_target,
   output logic              pred_tgt_valid,
   output logic              pred_from_btb,
   input  logic              rt_valid,
   input  logic [ADDR_W-1:0] rt_pc,
   input  logic              rt_taken,
   input  logic [ADDR_W-1:0] rt_target
);
   localparam int IDX_W = $clog2(BTB_ENTRIES);

   generate
      if ((1 << IDX_W) != BTB_ENTRIES) begin : g_bad_entries
         $error("BTB_ENTRIES must be a power of two");
      end
      if (ADDR_W < ALIGN_BITS + IDX_W + TAG_W) begin : g_bad_width
         $error("ADDR_W too narrow for index and tag fields");
      end
      if (RAS_DEPTH < 2) begin : g_bad_depth
         $error("RAS_DEPTH must be at least 2");
      end
      if (TAG_W < 0) begin : g_bad_tag
         $error("TAG_W must not be negative");
      end
   endgenerate

   logic              btb_hit, btb_taken;
   logic [ADDR_W-1:0] btb_target, ras_addr, fall_thru;
   logic              ras_valid, ras_push, ras_pop;

   assign fall_thru = fe_pc + ADDR_W'(INST_BYTES);
   assign ras_push  = fe_valid && fe_is_call && !fe_is_ret;
   assign ras_pop   = fe_valid && fe_is_ret;

   bp_btb #(
      .ADDR_W(ADDR_W), .ENTRIES(BTB_ENTRIES), .TAG_W(TAG_W), .ALIGN_BITS(ALIGN_BITS)
   ) btb_i (
      .clk(clk), .rst_n(rst_n),
      .lk_pc(fe_pc), .lk_hit(btb_hit), .lk_taken(btb_taken), .lk_target(btb_target),
      .up_valid(rt_valid), .up_pc(rt_pc), .up_taken(rt_taken), .up_target(rt_target)
   );

   bp_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) ras_i (
      .clk(clk), .rst_n(rst_n),
      .push(ras_push), .push_addr(fall_thru), .pop(ras_pop),
      .top_valid(ras_valid), .top_addr(ras_addr)
   );

   bp_pick #(.ADDR_W(ADDR_W)) pick_i (
      .is_ret(fe_is_ret), .disp_neg(fe_disp_neg),
      .btb_hit(btb_hit), .btb_taken(btb_taken), .btb_target(btb_target),
      .ras_valid(ras_valid), .ras_addr(ras_addr),
      .taken(pred_taken), .target(pred_target),
      .tgt_valid(pred_tgt_valid), .from_btb(pred_from_btb)
   );

endmodule

// File: rtl/bpred_static_fb_chk.sv
module bpred_static_fb_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fe_valid,
   input logic [ADDR_W-1:0] fe_pc,
   input logic              fe_disp_neg,
   input logic              fe_is_ret,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] pred_target,
   input logic              pred_tgt_valid,
   input logic              pred_from_btb,
   input logic              rt_valid,
   input logic [ADDR_W-1:0] rt_pc,
   input logic [ADDR_W-1:0] rt_target
);
   AST_MISS_BACKWARD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_valid && !fe_is_ret && !pred_from_btb && fe_disp_neg) |-> pred_taken); // R2

   AST_MISS_FORWARD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_valid && !fe_is_ret && !pred_from_btb && !fe_disp_neg) |-> !pred_taken && !pred_tgt_valid); // R3

   AST_RETIRE_ALLOCATES: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_valid && !fe_is_ret && $past(rt_valid) && fe_pc == $past(rt_pc))
      |-> pred_from_btb && pred_target == $past(rt_target)); // R4

   AST_RETURN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_valid && fe_is_ret) |-> pred_taken && !pred_from_btb); // R9
endmodule

bind bpred_static_fb bpred_static_fb_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_pc(fe_pc),
   .fe_disp_neg(fe_disp_neg), .fe_is_ret(fe_is_ret),
   .pred_taken(pred_taken), .pred_target(pred_target),
   .pred_tgt_valid(pred_tgt_valid), .pred_from_btb(pred_from_btb),
   .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_target(rt_target)
);

// File: tb/bpred_static_fb_tb_top.sv
module bpred_static_fb_tb_top;
   localparam int AW    = 32;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fe_valid = 1'b0, fe_disp_neg = 1'b0, fe_is_call = 1'b0, fe_is_ret = 1'b0;
   logic [AW-1:0] fe_pc = '0;
   logic          pred_taken, pred_tgt_valid, pred_from_btb;
   logic [AW-1:0] pred_target;
   logic          rt_valid = 1'b0, rt_taken = 1'b0;
   logic [AW-1:0] rt_pc = '0, rt_target = '0;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic          o_tk, o_tv, o_hit;
   logic [AW-1:0] o_tgt;

   always #5 clk = ~clk;

   bpred_static_fb dut_i (
      .clk(clk), .rst_n(rst_n),
      .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_disp_neg(fe_disp_neg),
      .fe_is_call(fe_is_call), .fe_is_ret(fe_is_ret),
      .pred_taken(pred_taken), .pred_target(pred_target),
      .pred_tgt_valid(pred_tgt_valid), .pred_from_btb(pred_from_btb),
      .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_taken(rt_taken), .rt_target(rt_target)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic fetch(input logic [AW-1:0] pc, input logic neg, input logic call, input logic ret);
      @(negedge clk);
      fe_valid = 1'b1; fe_pc = pc; fe_disp_neg = neg; fe_is_call = call; fe_is_ret = ret;
      #1;
      o_tk = pred_taken; o_tv = pred_tgt_valid; o_hit = pred_from_btb; o_tgt = pred_target;
      @(posedge clk); #1;
      fe_valid = 1'b0; fe_is_call = 1'b0; fe_is_ret = 1'b0;
   endtask

   task automatic retire(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tgt);
      @(negedge clk);
      rt_valid = 1'b1; rt_pc = pc; rt_taken = tk; rt_target = tgt;
      @(posedge clk); #1;
      rt_valid = 1'b0;
   endtask

   task automatic t_reset_state();
      fetch(32'h0000_1040, 1'b0, 1'b0, 1'b0);
      chk("R1 lookup after reset misses", o_hit, 0);
      fetch(32'h0000_0500, 1'b0, 1'b0, 1'b1);
      chk("R1 empty stack after reset", o_tv, 0);
      chk("R11 empty pop still taken", o_tk, 1);
   endtask

   task automatic t_static();
      fetch(32'h0000_4100, 1'b1, 1'b0, 1'b0);
      chk("R2 backward miss taken", o_tk, 1);
      chk("R2 backward miss no target", o_tv, 0);
      chk("R2 backward miss not from buffer", o_hit, 0);
      fetch(32'h0000_4200, 1'b0, 1'b0, 1'b0);
      chk("R3 forward miss not taken", o_tk, 0);
      chk("R3 forward miss no target", o_tv, 0);
   endtask

   task automatic t_fetch_no_write();
      fetch(32'h0000_4100, 1'b1, 1'b0, 1'b0);
      fetch(32'h0000_4100, 1'b0, 1'b0, 1'b0);
      chk("R5 repeated fetch still misses", o_hit, 0);
      chk("R5 repeated fetch static forward", o_tk, 0);
   endtask

   task automatic t_counter();
      logic [AW-1:0] pc = 32'h0000_3080;
      logic seq_tk  [9] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      logic exp_dir [9] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
      retire(pc, seq_tk[0], 32'h0000_3000);
      fetch(pc, 1'b1, 1'b0, 1'b0);
      chk("R4 allocated entry hits", o_hit, 1);
      chk("R4 allocated target", o_tgt, 32'h0000_3000);
      chk("R4 allocated target valid", o_tv, 1);
      chk("R6 seed weak not taken", o_tk, 0);
      for (int i = 1; i < 9; i++) begin
         retire(pc, seq_tk[i], 32'h0000_3000);
         fetch(pc, 1'b0, 1'b0, 1'b0);
         chk($sformatf("R6 counter step %0d", i), o_tk, exp_dir[i]);
      end
      retire(pc, 1'b1, 32'h0000_3000);
      fetch(pc, 1'b0, 1'b0, 1'b0);
      chk("R6 weak taken after rise", o_tk, 1);
   endtask

   task automatic t_replace();
      retire(32'h0000_1040, 1'b1, 32'h0000_AAA0);
      fetch(32'h0000_1040, 1'b0, 1'b0, 1'b0);
      chk("R4 seed weak taken", o_tk, 1);
      retire(32'h0000_2040, 1'b0, 32'h0000_BBB0);
      fetch(32'h0000_1040, 1'b0, 1'b0, 1'b0);
      chk("R7 evicted branch misses", o_hit, 0);
      fetch(32'h0000_2040, 1'b1, 1'b0, 1'b0);
      chk("R7 new branch hits", o_hit, 1);
      chk("R7 new branch target", o_tgt, 32'h0000_BBB0);
      chk("R7 new branch direction ignores sign", o_tk, 0);
      retire(32'h0000_2040, 1'b1, 32'h5555_0000);
      fetch(32'h0000_2040, 1'b0, 1'b0, 1'b0);
      chk("R8 target refreshed on hit", o_tgt, 32'h5555_0000);
      chk("R8 counter trained not reseeded", o_tk, 1);
   endtask

   task automatic t_ras_lifo();
      fetch(32'h0000_0100, 1'b0, 1'b1, 1'b0);
      fetch(32'h0000_0200, 1'b0, 1'b1, 1'b0);
      fetch(32'h0000_0300, 1'b1, 1'b1, 1'b0);
      for (int i = 3; i >= 1; i--) begin
         fetch(32'h0000_0900, 1'b0, 1'b0, 1'b1);
         chk("R9 return target", o_tgt, (i * 32'h100) + 32'h4);
         chk("R9 return target valid", o_tv, 1);
         chk("R9 return taken not from buffer", {o_tk, o_hit}, 2'b10);
      end
      fetch(32'h0000_0900, 1'b0, 1'b0, 1'b1);
      chk("R11 drained stack invalid", o_tv, 0);
   endtask

   task automatic t_ras_overflow();
      for (int i = 0; i < DEPTH + 2; i++)
         fetch(32'h0001_0000 + i * 16, 1'b0, 1'b1, 1'b0);
      for (int i = DEPTH + 1; i >= 2; i--) begin
         fetch(32'h0000_0900, 1'b0, 1'b0, 1'b1);
         chk($sformatf("R10 overflow pop %0d", i), {o_tv, o_tgt}, {1'b1, 32'h0001_0004 + i * 16});
      end
      fetch(32'h0000_0900, 1'b0, 1'b0, 1'b1);
      chk("R10 oldest entries overwritten", o_tv, 0);
      fetch(32'h0000_0900, 1'b0, 1'b0, 1'b1);
      chk("R11 repeated empty pop", {o_tk, o_tv}, 2'b10);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset_state();
      t_static();
      t_fetch_no_write();
      t_counter();
      t_replace();
      t_ras_lifo();
      t_ras_overflow();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule